// File: doc/BRIEF.md
# Temporal Partitioning Turn Scheduler

This block slices time into fixed turns and hands each turn to one security domain in a fixed round-robin order. The order and the turn lengths never depend on demand. Each domain may have its own static turn length. A memory controller reads `active_dom` to learn which domain's queue it may serve. It may start a transaction only while `issue_en` is high. Because the timing of every turn is fixed and public, a domain's memory timing cannot reveal anything about the traffic of another domain.

Near the end of each turn, `issue_en` drops for a dead window. The dead window lets any transaction already in flight drain before the next domain takes over. The window is sized from the worst-case drain time, which is built from DRAM timing parameters. In a bank-partitioned variant, a shorter formula is used instead. The refresh schedule is public, so the host raises `refresh_due` in the first cycle of any turn that carries a refresh. That turn's dead window then grows by the refresh time. When the longer window exceeds the turn length, the whole turn is dead.

Top module: `tp_sched`

## Requirements
- R1: After reset, and again after any later reset, the first cycle is the first cycle of a turn of domain 0. In that cycle `active_dom` is 0 and `turn_first` is 1.
- R2: `active_dom` carries the binary index of the active domain. At each turn boundary it steps from 0 upward to NUM_DOM-1, then back to 0.
- R3: A turn of domain d lasts exactly L_d cycles, with the defaults L_0=200, L_1=64 and L_2=46. `turn_first` is 1 only in the first cycle of a turn, and `active_dom` holds steady for the whole turn.
- R4: Let p be the position within a turn, counted from 0, in a turn with no refresh. `issue_en` is 1 exactly when p + D <= L_d. Here D is the worst-case write drain tCWD+tBURST+tWR+tRP+tRCD, which is 5+4+15+11+11 = 46 cycles by default.
- R5: `refresh_due` is sampled in the cycle where `turn_first` is 1, and it applies to the whole of that turn. In a refresh turn, `issue_en` is 1 exactly when p + D + tRFC <= L_d, with tRFC = 50 by default.
- R6: In a refresh turn where L_d < D + tRFC, `issue_en` stays 0 for the entire turn.
- R7: For a domain whose turn length equals D (domain 2 by default), a turn with no refresh enables issue only in its first cycle.
- R8: With BANK_PART=1, D becomes the largest of tFAW-3*tRRD, tCWD+tBURST+tWTR and tCAS+tBURST+tRTRS-tCWD. By default that is max(18,15,12) = 18 cycles, and R4 to R6 apply with this D.
- R9: A value on `refresh_due` outside the first cycle of a turn has no effect on `issue_en`.
- R10: Across turns with no refresh, the gap between two consecutive issue-enabled cycles of a domain d is at most the sum of all turn lengths minus L_d plus D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_due | input | 1 | A refresh is scheduled in the turn now starting; sampled while turn_first is 1 |
| active_dom | output | DOM_W | Index of the domain that owns the current turn |
| issue_en | output | 1 | The active domain may start a transaction this cycle |
| turn_first | output | 1 | First cycle of a turn |

## Verification
The assertions assume that every turn length is at least the drain time D and fits in LEN_W bits. They also assume that `refresh_due` is a clean level in the first cycle of each turn. Both benches keep their lengths at or above D; the default instance includes a turn exactly equal to D. The refresh input is changed only just after a rising edge. It is held high for whole turns, held low for whole rounds, and toggled every cycle by a pseudo-random sequence, so that the effect of a mid-turn value is exercised alongside clean samples.

// File: rtl/tp_pkg.sv
// Package: shared timing arithmetic for the turn scheduler.
// Assumes all timing values are given in controller clock cycles.
package tp_pkg;

    // Worst-case drain of a write transaction followed by its precharge.
    function automatic int unsigned f_write_drain(
        int unsigned cwd, int unsigned burst, int unsigned wr,
        int unsigned rp, int unsigned rcd);
        return cwd + burst + wr + rp + rcd;
    endfunction

    // Largest of three values.
    function automatic int unsigned f_max3(
        int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Dead time when domains own disjoint banks; negative terms clamp to zero.
    function automatic int unsigned f_bank_dead(
        int unsigned faw, int unsigned rrd, int unsigned cwd,
        int unsigned burst, int unsigned wtr, int unsigned cas,
        int unsigned rtrs);
        int unsigned t_act;
        int unsigned t_wr2rd;
        int unsigned t_rd2wr;
        t_act   = (faw > 3 * rrd) ? faw - 3 * rrd : 0;
        t_wr2rd = cwd + burst + wtr;
        t_rd2wr = (cas + burst + rtrs > cwd) ? cas + burst + rtrs - cwd : 0;
        return f_max3(t_act, t_wr2rd, t_rd2wr);
    endfunction

endpackage

// File: rtl/tp_len_table.sv
// Module: tp_len_table
// Unpacks the static per-domain turn lengths and gives the length of the
// current domain, the next domain in round-robin order, and its length.
// Assumes dom is always below NUM_DOM.
module tp_len_table #(
    parameter int unsigned NUM_DOM = 3,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned DOM_W   = 2,
    parameter logic [NUM_DOM*LEN_W-1:0] TURN_LEN = '0
) (
    input  logic [DOM_W-1:0] dom,
    output logic [DOM_W-1:0] nxt_dom,
    output logic [LEN_W-1:0] nxt_len,
    output logic [LEN_W-1:0] first_len
);

    logic [LEN_W-1:0] tab [NUM_DOM];

    // One table entry per domain, taken from the packed parameter.
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_tab
        assign tab[g] = TURN_LEN[g*LEN_W +: LEN_W];
    end

    assign first_len = tab[0];

    // Fixed round-robin successor of the current domain.
    always_comb begin
        if (dom == DOM_W'(NUM_DOM - 1)) begin
            nxt_dom = '0;
        end else begin
            nxt_dom = dom + 1'b1;
        end
    end

    // Look up the successor's turn length.
    always_comb begin
        nxt_len = tab[0];
        for (int i = 0; i < NUM_DOM; i++) begin
            if (nxt_dom == DOM_W'(i)) begin
                nxt_len = tab[i];
            end
        end
    end

endmodule

// File: rtl/tp_turn_ctr.sv
// Module: tp_turn_ctr
// Down-counts the cycles left in the current turn and advances the domain
// when the count expires. rem holds the cycles remaining including the
// current one. Assumes every turn length is at least 1.
module tp_turn_ctr #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned DOM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DOM_W-1:0] nxt_dom,
    input  logic [LEN_W-1:0] nxt_len,
    input  logic [LEN_W-1:0] first_len,
    output logic [DOM_W-1:0] dom,
    output logic [LEN_W-1:0] rem,
    output logic             first
);

    logic last_cycle;

    // The turn ends after the cycle with one cycle remaining.
    assign last_cycle = (rem <= LEN_W'(1));

    // Turn counter, owner register and turn-start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom   <= '0;
            rem   <= first_len;
            first <= 1'b1;
        end else if (last_cycle) begin
            dom   <= nxt_dom;
            rem   <= nxt_len;
            first <= 1'b1;
        end else begin
            rem   <= rem - 1'b1;
            first <= 1'b0;
        end
    end

endmodule

// File: rtl/tp_dead_window.sv
// Module: tp_dead_window
// Decides whether the active domain may issue in the current cycle. The
// refresh flag is taken in the first cycle of a turn and held for the rest
// of it. An issue is allowed only if the chosen dead length still fits in
// the remaining cycles. A refresh turn too short for the longer window is
// wholly dead. Assumes rem counts the remaining cycles including this one.
module tp_dead_window #(
    parameter int unsigned NUM_DOM   = 3,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned DOM_W     = 2,
    parameter logic [NUM_DOM*LEN_W-1:0] TURN_LEN = '0,
    parameter int unsigned BASE_DEAD = 46,
    parameter int unsigned T_RFC     = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic [LEN_W-1:0] rem,
    input  logic [DOM_W-1:0] dom,
    input  logic             refresh_due,
    output logic             issue_en
);

    localparam int unsigned REF_DEAD = BASE_DEAD + T_RFC;

    logic [NUM_DOM-1:0] whole_dead;
    logic               ref_q;
    logic               ref_eff;
    logic               dom_whole;
    logic [31:0]        dead_len;

    // Per-domain flag: a refresh turn of this domain has no issue slot.
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_whole
        localparam logic [LEN_W-1:0] LG = TURN_LEN[g*LEN_W +: LEN_W];
        assign whole_dead[g] = (32'(LG) < REF_DEAD);
    end

    // Hold the refresh flag sampled at the start of the turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (first) begin
            ref_q <= refresh_due;
        end
    end

    // The flag in force this cycle: live at the turn start, held after.
    assign ref_eff = first ? refresh_due : ref_q;

    // Select the whole-turn flag of the active domain.
    always_comb begin
        dom_whole = 1'b0;
        for (int i = 0; i < NUM_DOM; i++) begin
            if (dom == DOM_W'(i)) begin
                dom_whole = whole_dead[i];
            end
        end
    end

    // Dead length for this turn and the issue decision.
    always_comb begin
        dead_len = ref_eff ? 32'(REF_DEAD) : 32'(BASE_DEAD);
        issue_en = !(ref_eff && dom_whole) && (32'(rem) >= dead_len);
    end

endmodule

// File: rtl/tp_sched.sv
// Module: tp_sched (top)
// Static round-robin turn scheduler with a per-turn dead window. The
// parameter BANK_PART picks the dead-time formula. Assumes each turn length
// is at least the base dead time and fits in LEN_W bits. TURN_LEN packs
// domain 0 in the low LEN_W bits.
module tp_sched #(
    parameter int unsigned NUM_DOM   = 3,
    parameter int unsigned LEN_W     = 16,
    parameter logic [NUM_DOM*LEN_W-1:0] TURN_LEN = {16'd46, 16'd64, 16'd200},
    parameter bit          BANK_PART = 1'b0,
    parameter int unsigned T_CWD     = 5,
    parameter int unsigned T_BURST   = 4,
    parameter int unsigned T_WR      = 15,
    parameter int unsigned T_RP      = 11,
    parameter int unsigned T_RCD     = 11,
    parameter int unsigned T_RFC     = 50,
    parameter int unsigned T_FAW     = 24,
    parameter int unsigned T_RRD     = 2,
    parameter int unsigned T_WTR     = 6,
    parameter int unsigned T_CAS     = 11,
    parameter int unsigned T_RTRS    = 2,
    localparam int unsigned DOM_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_due,
    output logic [DOM_W-1:0] active_dom,
    output logic             issue_en,
    output logic             turn_first
);

    localparam int unsigned BASE_DEAD = BANK_PART ?
        tp_pkg::f_bank_dead(T_FAW, T_RRD, T_CWD, T_BURST, T_WTR, T_CAS, T_RTRS) :
        tp_pkg::f_write_drain(T_CWD, T_BURST, T_WR, T_RP, T_RCD);

    logic [DOM_W-1:0] dom;
    logic [DOM_W-1:0] nxt_dom;
    logic [LEN_W-1:0] nxt_len;
    logic [LEN_W-1:0] first_len;
    logic [LEN_W-1:0] rem;
    logic             first;

    tp_len_table #(
        .NUM_DOM (NUM_DOM),
        .LEN_W   (LEN_W),
        .DOM_W   (DOM_W),
        .TURN_LEN(TURN_LEN)
    ) u_tab (
        .dom      (dom),
        .nxt_dom  (nxt_dom),
        .nxt_len  (nxt_len),
        .first_len(first_len)
    );

    tp_turn_ctr #(
        .LEN_W(LEN_W),
        .DOM_W(DOM_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_dom  (nxt_dom),
        .nxt_len  (nxt_len),
        .first_len(first_len),
        .dom      (dom),
        .rem      (rem),
        .first    (first)
    );

    tp_dead_window #(
        .NUM_DOM  (NUM_DOM),
        .LEN_W    (LEN_W),
        .DOM_W    (DOM_W),
        .TURN_LEN (TURN_LEN),
        .BASE_DEAD(BASE_DEAD),
        .T_RFC    (T_RFC)
    ) u_dead (
        .clk        (clk),
        .rst_n      (rst_n),
        .first      (first),
        .rem        (rem),
        .dom        (dom),
        .refresh_due(refresh_due),
        .issue_en   (issue_en)
    );

    assign active_dom = dom;
    assign turn_first = first;

endmodule

// File: rtl/tp_sched_chk.sv
// Module: tp_sched_chk
// Property checker for tp_sched, attached by bind. It tracks the position
// within a turn and the sampled refresh flag from the ports alone.
module tp_sched_chk #(
    parameter int unsigned NUM_DOM   = 3,
    parameter int unsigned LEN_W     = 16,
    parameter logic [NUM_DOM*LEN_W-1:0] TURN_LEN = '0,
    parameter int unsigned BASE_DEAD = 46,
    parameter int unsigned T_RFC     = 50,
    parameter int unsigned DOM_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             refresh_due,
    input logic [DOM_W-1:0] active_dom,
    input logic             issue_en,
    input logic             turn_first
);

    logic [31:0] pos_q;
    logic [31:0] cur_pos;
    logic        ref_c;
    logic        eff;

    // Turn length of a domain index, from the parameter.
    function automatic logic [31:0] len_of(logic [DOM_W-1:0] d);
        logic [31:0] r;
        r = 32'(TURN_LEN[LEN_W-1:0]);
        for (int i = 0; i < NUM_DOM; i++) begin
            if (d == DOM_W'(i)) begin
                r = 32'(TURN_LEN[i*LEN_W +: LEN_W]);
            end
        end
        return r;
    endfunction

    // Round-robin successor of a domain index.
    function automatic logic [DOM_W-1:0] succ(logic [DOM_W-1:0] d);
        return (d == DOM_W'(NUM_DOM - 1)) ? '0 : d + 1'b1;
    endfunction

    // Position tracker and refresh sample, driven only by the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= 32'd1;
            ref_c <= 1'b0;
        end else begin
            pos_q <= turn_first ? 32'd1 : pos_q + 32'd1;
            if (turn_first) begin
                ref_c <= refresh_due;
            end
        end
    end

    assign cur_pos = turn_first ? 32'd0 : pos_q;
    assign eff     = turn_first ? refresh_due : ref_c;

    // R4: issue is never granted inside the base dead window.
    a_r4_issue_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> (cur_pos + BASE_DEAD <= len_of(active_dom)));

    // R4: the issue window is a prefix of the turn.
    a_r4_window_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && !turn_first) |-> $past(issue_en));

    // R6: a refresh turn shorter than the longer window stays dead.
    a_r6_whole_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (eff && (len_of(active_dom) < BASE_DEAD + T_RFC)) |-> !issue_en);

    // R5: a refresh turn also keeps out of the longer dead window.
    a_r5_refresh_window: assert property (@(posedge clk) disable iff (!rst_n)
        (eff && issue_en) |-> (cur_pos + BASE_DEAD + T_RFC <= len_of(active_dom)));

    // R3: each turn lasts exactly its own length.
    a_r3_turn_length: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_first && $past(rst_n)) |-> ($past(cur_pos) + 32'd1 == len_of($past(active_dom))));

    // R3: the owner is steady within a turn.
    a_r3_dom_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !turn_first |-> $stable(active_dom));

    // R2: owners follow round-robin order.
    a_r2_rr_order: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_first && $past(rst_n)) |-> (active_dom == succ($past(active_dom))));

endmodule

bind tp_sched tp_sched_chk #(
    .NUM_DOM  (NUM_DOM),
    .LEN_W    (LEN_W),
    .TURN_LEN (TURN_LEN),
    .BASE_DEAD(BASE_DEAD),
    .T_RFC    (T_RFC),
    .DOM_W    (DOM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh_due(refresh_due),
    .active_dom (active_dom),
    .issue_en   (issue_en),
    .turn_first (turn_first)
);

// File: tb/tp_sched_tb.sv
// Bench for tp_sched: a behavioural per-cycle model compared on every clock
// against a default instance and a bank-partitioned instance.
module tp_sched_tb;

    localparam int NUM  = 3;
    localparam int L0 = 200, L1 = 64, L2 = 46;
    localparam int DW   = 46;   // 5+4+15+11+11
    localparam int DB   = 18;   // max(24-6, 5+4+6, 11+4+2-5)
    localparam int RFC  = 50;
    localparam int SUM  = L0 + L1 + L2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_due = 1'b0;
    logic [1:0] dom_a, dom_b;
    logic       iss_a, iss_b, first_a, first_b;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    int  m_dom = 0, m_pos = 0;
    bit  m_ref = 1'b0, m_valid = 1'b0;
    bit  nr_phase = 1'b0;
    int  cyc = 0;
    int  last_en [NUM];

    always #10 clk = ~clk;

    tp_sched u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_due(refresh_due),
        .active_dom(dom_a), .issue_en(iss_a), .turn_first(first_a)
    );

    tp_sched #(.BANK_PART(1'b1)) u_dut_bp (
        .clk(clk), .rst_n(rst_n), .refresh_due(refresh_due),
        .active_dom(dom_b), .issue_en(iss_b), .turn_first(first_b)
    );

    function automatic int len_of(int d);
        return (d == 0) ? L0 : (d == 1) ? L1 : L2;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dom = 0; m_pos = 0; m_ref = 1'b0; m_valid = 1'b1;
        end else begin
            if (m_pos == 0) m_ref = refresh_due;
            if (m_pos == len_of(m_dom) - 1) begin
                m_dom = (m_dom + 1) % NUM;
                m_pos = 0;
            end else begin
                m_pos++;
            end
        end
    end

    // Compare both instances with the model away from the rising edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            bit    eff;
            bit    exp_a, exp_b;
            int    L;
            string tag_a, tag_b;
            cyc++;
            L     = len_of(m_dom);
            eff   = (m_pos == 0) ? refresh_due : m_ref;
            exp_a = (m_pos + (eff ? DW + RFC : DW)) <= L;
            exp_b = (m_pos + (eff ? DB + RFC : DB)) <= L;
            if (m_pos != 0 && refresh_due != m_ref) tag_a = "R9";
            else if (eff && L < DW + RFC) tag_a = "R6";
            else if (eff) tag_a = "R5";
            else if (L == DW) tag_a = "R7";
            else tag_a = "R4";
            tag_b = "R8";
            chk(int'(dom_a) == m_dom, "R2 domain", int'(dom_a), m_dom);
            chk(int'(dom_b) == m_dom, "R2 domain bank-mode", int'(dom_b), m_dom);
            chk(first_a == (m_pos == 0), "R3 turn_first", int'(first_a), int'(m_pos == 0));
            chk(iss_a == exp_a, tag_a, int'(iss_a), int'(exp_a));
            chk(iss_b == exp_b, tag_b, int'(iss_b), int'(exp_b));
            // R10: gap between issue-enabled cycles of a domain
            if (nr_phase && rst_n && iss_a) begin
                int d;
                d = int'(dom_a);
                if (d < NUM) begin
                    if (last_en[d] >= 0 && cyc - last_en[d] > 1) begin
                        chk(cyc - last_en[d] <= SUM - len_of(d) + DW, "R10 wait bound",
                            cyc - last_en[d], SUM - len_of(d) + DW);
                    end
                    last_en[d] = cyc;
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        chk(dom_a == 2'd0, "R1 domain after reset", int'(dom_a), 0);
        chk(first_a == 1'b1, "R1 turn_first after reset", int'(first_a), 1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int i = 0; i < NUM; i++) last_en[i] = -1;
        rst_n = 1'b0;
        step(4);
        rst_n = 1'b1;
        check_reset_state();
        step(1);
        // Three rounds with no refresh: R4, R7, R10.
        nr_phase = 1'b1;
        step(3 * SUM);
        nr_phase = 1'b0;
        // One round with refresh in every turn: R5, R6.
        refresh_due = 1'b1;
        step(SUM);
        refresh_due = 1'b0;
        step(SUM);
        // Refresh toggled every cycle: R5, R6, R9.
        for (int i = 0; i < 4 * SUM; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            refresh_due = lfsr[0];
            step(1);
        end
        refresh_due = 1'b0;
        // Reset in the middle of a turn: R1 again.
        step(37);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        check_reset_state();
        step(SUM + 10);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule